// File: doc/BRIEF.md
# Clock-Master Double-Buffered Serial Receiver

This block receives 8-bit frames over a synchronous serial link on which it is the clock master. It drives a serial clock derived from the system clock through a programmable divider, samples the serial data input on each rising clock edge, and assembles each frame least significant bit first in a shift register. A host-side mode input selects between two ways of handing frames to the host.

With one buffer, the shift register is what the host reads. The serial clock runs for one frame and then stops until the host reads that byte. With two buffers, each finished frame moves into a holding register and reception of the next frame begins straight away. When a frame finishes while the holding register is still occupied, the block raises an overrun flag. It keeps the new frame in the shift register and holds the serial clock high. The host's next read moves the waiting frame forward and restarts the clock. Because the block masters the clock, flow control needs no extra wiring.

Top module: `sync_rx_dbuf`

## Requirements
- R1: After reset, `sck_o` is 1 and `buf_full`, `ovr_flag` and `rx_irq` are 0.
- R2: While a frame is being received, `sck_o` is low for `cfg_div`+1 system cycles and then high for `cfg_div`+1 cycles, so consecutive falling edges within a frame are 2*(`cfg_div`+1) cycles apart. When stopped, `sck_o` stays at 1. No clock edges occur while `rx_en` is 0 and no frame is in progress.
- R3: `sdi` is sampled on each rising edge of `sck_o`. The first sample becomes bit 0 of the byte, and the eighth sample becomes bit 7.
- R4: With `dbl_mode`=0, raising `rx_en` starts one frame. When the frame ends, `rx_irq` pulses and `rd_data` shows the byte. `sck_o` then stays high until a `rd_strobe`, and each such read releases exactly one further frame.
- R5: With `dbl_mode`=0, `buf_full` stays 0 and `ovr_flag` is never set.
- R6: With `dbl_mode`=1, a finished frame moves into the holding register when that register is empty or is being read in the same cycle. This sets `buf_full`, pulses `rx_irq` and shows the byte on `rd_data`. The next frame starts without waiting for a host read.
- R7: With `dbl_mode`=1, a `rd_strobe` while no frame is waiting in the shift register clears `buf_full` in the next cycle.
- R8: With `dbl_mode`=1, if a frame finishes while `buf_full` is 1 and no read occurs, then `ovr_flag` becomes 1 and no `rx_irq` pulse is produced. `sck_o` stays high, and `rd_data` keeps the older byte.
- R9: After an overrun, a `rd_strobe` moves the waiting byte into the holding register. It pulses `rx_irq` in the following cycle, keeps `buf_full` at 1, and restarts the serial clock.
- R10: `ovr_flag` stays 1, across host reads, until a one-cycle `ovr_clr` pulse clears it.
- R11: `rx_irq` is never high for two consecutive cycles.
- R12: Dropping `rx_en` in the middle of a frame lets that frame finish and be delivered. After that, no further clock edges occur and the bit position restarts at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_div | input | DIV_W | Serial clock half-period, in system cycles, minus one |
| rx_en | input | 1 | Receive enable |
| dbl_mode | input | 1 | 0: single buffer, 1: shift register plus holding register |
| rd_strobe | input | 1 | One-cycle host read of the received byte |
| ovr_clr | input | 1 | One-cycle pulse that clears the overrun flag |
| sdi | input | 1 | Serial data input |
| sck_o | output | 1 | Serial clock output, idles high |
| rd_data | output | FRAME_W | Received byte (shift register in single mode, holding register in double mode) |
| buf_full | output | 1 | Holding register contains an unread byte |
| ovr_flag | output | 1 | Sticky overrun indication |
| rx_irq | output | 1 | One-cycle receive interrupt pulse |

## Verification
The bench builds the block with FRAME_W=8 and DIV_W=8. An 8-bit frame makes an exhaustive sweep practical: in double-buffer mode at the fastest divider setting, 256 back-to-back frames deliver every byte value. Single-buffer mode is exercised at divider values 0, 1 and 3, which shows that the serial clock period scales with the setting and that the clock stops between host reads. The overrun stall and its recovery, the sticky overrun flag, and a mid-frame drop of the enable are each set up deliberately, using the shortest divider values so that every scenario completes within a few dozen cycles per frame.

// File: rtl/sync_rx_pkg.sv
package sync_rx_pkg;

  // Buffering mode selected by the host
  typedef enum logic {
    MODE_SINGLE = 1'b0,
    MODE_DOUBLE = 1'b1
  } rx_mode_e;

endpackage

// File: rtl/srx_clkgen.sv
// Serial clock master: divider, clock level and bit position (R2, R3, R12)
module srx_clkgen #(
  parameter int FRAME_W = 8,
  parameter int DIV_W   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_i,
  input  logic             go_i,
  output logic             sck_o,
  output logic             smp_o,
  output logic             last_o
);

  localparam int CNT_W = (FRAME_W > 1) ? $clog2(FRAME_W) : 1;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_W - 1);

  logic [DIV_W-1:0] div_q, div_d;
  logic             sck_q, sck_d;
  logic             sck_en;
  logic [CNT_W-1:0] bit_q, bit_d;
  logic             tick;

  assign tick = (div_q >= div_i);

  always_comb begin
    div_d  = tick ? '0 : div_q + 1'b1;
    sck_d  = sck_q;
    sck_en = 1'b0;
    bit_d  = bit_q;
    smp_o  = 1'b0;
    if (tick) begin
      if (sck_q) begin
        // Falling edge only mid-frame or when a new frame may start
        if ((bit_q != '0) || go_i) begin
          sck_d  = 1'b0;
          sck_en = 1'b1;
        end
      end else begin
        sck_d  = 1'b1;
        sck_en = 1'b1;
        smp_o  = 1'b1;
        bit_d  = (bit_q == LAST_BIT) ? '0 : bit_q + 1'b1;
      end
    end
  end

  assign last_o = smp_o && (bit_q == LAST_BIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      sck_q <= 1'b1;
      bit_q <= '0;
    end else begin
      div_q <= div_d;
      if (sck_en) begin
        sck_q <= sck_d;
        bit_q <= bit_d;
      end
    end
  end

  assign sck_o = sck_q;

endmodule

// File: rtl/srx_shifter.sv
// First-stage shift register, least significant bit arrives first (R3)
module srx_shifter #(
  parameter int FRAME_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               smp_i,
  input  logic               sdi_i,
  output logic [FRAME_W-1:0] data_q_o,
  output logic [FRAME_W-1:0] data_nxt_o
);

  logic [FRAME_W-1:0] sh_q;

  generate
    if (FRAME_W > 1) begin : g_wide
      assign data_nxt_o = {sdi_i, sh_q[FRAME_W-1:1]};
    end else begin : g_bit
      assign data_nxt_o = sdi_i;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
    end else if (smp_i) begin
      sh_q <= data_nxt_o;
    end
  end

  assign data_q_o = sh_q;

endmodule

// File: rtl/srx_bufctl.sv
// Holding register, flags and interrupt (R4-R11)
module srx_bufctl
  import sync_rx_pkg::*;
#(
  parameter int FRAME_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  rx_mode_e           mode_i,
  input  logic               done_i,
  input  logic               rd_i,
  input  logic               ovr_clr_i,
  input  logic [FRAME_W-1:0] sh_nxt_i,
  input  logic [FRAME_W-1:0] sh_q_i,
  output logic [FRAME_W-1:0] hold_o,
  output logic               buf_full_o,
  output logic               sh_full_o,
  output logic               ovr_o,
  output logic               irq_o
);

  logic [FRAME_W-1:0] hold_q, hold_d;
  logic               hold_en;
  logic               full_q, full_d;
  logic               shf_q, shf_d;
  logic               ovr_q, ovr_d;
  logic               irq_d;

  always_comb begin
    hold_d  = hold_q;
    hold_en = 1'b0;
    full_d  = full_q;
    shf_d   = shf_q;
    ovr_d   = ovr_q;
    irq_d   = 1'b0;
    if (done_i) begin
      if (mode_i == MODE_DOUBLE) begin
        if (!full_q || rd_i) begin
          hold_d  = sh_nxt_i;
          hold_en = 1'b1;
          full_d  = 1'b1;
          irq_d   = 1'b1;
        end else begin
          shf_d = 1'b1;   // overrun: park frame, stall clock (R8)
          ovr_d = 1'b1;
        end
      end else begin
        shf_d = 1'b1;     // single buffer: wait for host read (R4)
        irq_d = 1'b1;
      end
    end else if (rd_i) begin
      if (mode_i == MODE_DOUBLE) begin
        if (shf_q) begin
          hold_d  = sh_q_i; // recovery after overrun (R9)
          hold_en = 1'b1;
          shf_d   = 1'b0;
          full_d  = 1'b1;
          irq_d   = 1'b1;
        end else begin
          full_d = 1'b0;  // R7
        end
      end else begin
        shf_d = 1'b0;
      end
    end
    if (ovr_clr_i && !(done_i && (mode_i == MODE_DOUBLE) && full_q && !rd_i)) begin
      ovr_d = 1'b0;       // R10: set wins over clear
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      full_q <= 1'b0;
      shf_q  <= 1'b0;
      ovr_q  <= 1'b0;
      irq_o  <= 1'b0;
    end else begin
      if (hold_en) hold_q <= hold_d;
      full_q <= full_d;
      shf_q  <= shf_d;
      ovr_q  <= ovr_d;
      irq_o  <= irq_d;
    end
  end

  assign hold_o     = hold_q;
  assign buf_full_o = full_q;
  assign sh_full_o  = shf_q;
  assign ovr_o      = ovr_q;

endmodule

// File: rtl/sync_rx_dbuf.sv
module sync_rx_dbuf
  import sync_rx_pkg::*;
#(
  parameter int FRAME_W = 8,
  parameter int DIV_W   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [DIV_W-1:0]   cfg_div,
  input  logic               rx_en,
  input  logic               dbl_mode,
  input  logic               rd_strobe,
  input  logic               ovr_clr,
  input  logic               sdi,
  output logic               sck_o,
  output logic [FRAME_W-1:0] rd_data,
  output logic               buf_full,
  output logic               ovr_flag,
  output logic               rx_irq
);

  logic [1:0]         rst_sync;
  logic               rst_q_n;
  logic               smp, last, go, sh_full;
  logic [FRAME_W-1:0] sh_q, sh_nxt, hold;
  rx_mode_e           mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q_n = rst_sync[1];

  assign mode = rx_mode_e'(dbl_mode);
  assign go   = rx_en && !sh_full;

  srx_clkgen #(.FRAME_W(FRAME_W), .DIV_W(DIV_W)) clkgen_i (
    .clk(clk), .rst_n(rst_q_n), .div_i(cfg_div), .go_i(go),
    .sck_o(sck_o), .smp_o(smp), .last_o(last)
  );

  srx_shifter #(.FRAME_W(FRAME_W)) shifter_i (
    .clk(clk), .rst_n(rst_q_n), .smp_i(smp), .sdi_i(sdi),
    .data_q_o(sh_q), .data_nxt_o(sh_nxt)
  );

  srx_bufctl #(.FRAME_W(FRAME_W)) bufctl_i (
    .clk(clk), .rst_n(rst_q_n), .mode_i(mode), .done_i(last),
    .rd_i(rd_strobe), .ovr_clr_i(ovr_clr), .sh_nxt_i(sh_nxt), .sh_q_i(sh_q),
    .hold_o(hold), .buf_full_o(buf_full), .sh_full_o(sh_full),
    .ovr_o(ovr_flag), .irq_o(rx_irq)
  );

  assign rd_data = (mode == MODE_DOUBLE) ? hold : sh_q;

endmodule

// File: rtl/srx_chk.sv
module srx_chk (
  input logic clk,
  input logic rst_n,
  input logic sck,
  input logic irq,
  input logic full,
  input logic ovr,
  input logic ovr_clr,
  input logic dbl,
  input logic sh_full
);

  assert_irq_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  assert_ovr_no_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr) |-> !irq);

  assert_stall_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sh_full && sck) |=> sck);

  assert_ovr_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr && !ovr_clr) |=> ovr);

  assert_single_no_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!dbl && !full) |=> !full);

  assert_irq_with_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (dbl && irq) |-> full);

endmodule

bind sync_rx_dbuf srx_chk chk_i (
  .clk(clk), .rst_n(rst_q_n), .sck(sck_o), .irq(rx_irq), .full(buf_full),
  .ovr(ovr_flag), .ovr_clr(ovr_clr), .dbl(dbl_mode), .sh_full(sh_full)
);

// File: tb/sync_rx_dbuf_tb_top.sv
`timescale 1ns/1ps
module sync_rx_dbuf_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] cfg_div = '0;
  logic       rx_en = 1'b0, dbl_mode = 1'b0, rd_strobe = 1'b0, ovr_clr = 1'b0;
  logic       sdi = 1'b0;
  logic       sck_o, buf_full, ovr_flag, rx_irq;
  logic [7:0] rd_data;

  int n_chk = 0, n_fail = 0;
  int cyc = 0, bitidx = 0, nfall = 0, last_fall = 0, last_per = 0, nirq = 0;
  int next_rx = 0;
  bit done = 0;

  always #5 clk = ~clk;

  sync_rx_dbuf #(.FRAME_W(8), .DIV_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div), .rx_en(rx_en),
    .dbl_mode(dbl_mode), .rd_strobe(rd_strobe), .ovr_clr(ovr_clr), .sdi(sdi),
    .sck_o(sck_o), .rd_data(rd_data), .buf_full(buf_full),
    .ovr_flag(ovr_flag), .rx_irq(rx_irq)
  );

  always @(posedge clk) cyc <= cyc + 1;
  always @(posedge clk) if (rx_irq) nirq <= nirq + 1;

  function automatic logic [7:0] exp_byte(input int k);
    return 8'((k * 7 + 3) & 255);
  endfunction

  // Serial source: present the next bit after each falling clock edge
  initial begin
    forever begin
      @(negedge sck_o);
      #1;
      if ((bitidx % 8) != 0) last_per = cyc - last_fall;
      last_fall = cyc;
      nfall = nfall + 1;
      sdi = exp_byte(bitidx / 8)[bitidx % 8];
      bitidx = bitidx + 1;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_irq(input int lim, output bit got);
    got = 0;
    for (int i = 0; i < lim; i++) begin
      @(negedge clk);
      if (rx_irq) begin got = 1; break; end
    end
  endtask

  task automatic do_read();
    rd_strobe = 1'b1;
    @(negedge clk);
    rd_strobe = 1'b0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    bit got;
    int n0, ni;
    int divs[3] = '{0, 1, 3};
    logic [7:0] exp_a;

    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(sck_o == 1'b1, "R1 sck", int'(sck_o), 1);
    check(buf_full == 1'b0, "R1 buf_full", int'(buf_full), 0);
    check(ovr_flag == 1'b0, "R1 ovr", int'(ovr_flag), 0);
    check(rx_irq == 1'b0, "R1 irq", int'(rx_irq), 0);
    repeat (40) @(negedge clk);
    check(nfall == 0, "R2 idle without enable", nfall, 0);

    // Single-buffer sweep over divider values (R2, R3, R4, R5, R11)
    cfg_div = 8'(divs[0]);
    rx_en = 1'b1;
    for (int d = 0; d < 3; d++) begin
      for (int f = 0; f < 4; f++) begin
        wait_irq(3000, got);
        check(got, "R4 frame delivered", int'(got), 1);
        check(rd_data == exp_byte(next_rx), "R3 byte order", int'(rd_data), int'(exp_byte(next_rx)));
        next_rx++;
        check(buf_full == 1'b0, "R5 no buf_full", int'(buf_full), 0);
        check(ovr_flag == 1'b0, "R5 no overrun", int'(ovr_flag), 0);
        check(last_per == 2 * (divs[d] + 1), "R2 period", last_per, 2 * (divs[d] + 1));
        @(negedge clk);
        check(rx_irq == 1'b0, "R11 pulse width", int'(rx_irq), 0);
        n0 = nfall;
        repeat (4 * (divs[d] + 1) + 8) @(negedge clk);
        check(nfall == n0, "R4 clock waits for read", nfall - n0, 0);
        check(sck_o == 1'b1, "R2 idles high", int'(sck_o), 1);
        if (f == 3) begin
          if (d < 2) cfg_div = 8'(divs[d + 1]);
          else rx_en = 1'b0;
        end
        do_read();
      end
    end
    n0 = nfall;
    repeat (40) @(negedge clk);
    check(nfall == n0, "R2 no clock when disabled", nfall - n0, 0);

    // Double-buffer exhaustive byte sweep (R6, R7)
    dbl_mode = 1'b1;
    cfg_div = 8'd0;
    rx_en = 1'b1;
    for (int i = 0; i < 256; i++) begin
      wait_irq(500, got);
      check(got, "R6 irq on transfer", int'(got), 1);
      check(buf_full == 1'b1, "R6 buf_full set", int'(buf_full), 1);
      check(rd_data == exp_byte(next_rx), "R6 held byte", int'(rd_data), int'(exp_byte(next_rx)));
      next_rx++;
      if (i == 100) begin
        n0 = nfall;
        repeat (6) @(negedge clk);
        check(nfall > n0, "R6 next frame without read", nfall - n0, 1);
      end
      do_read();
      check(buf_full == 1'b0, "R7 read clears full", int'(buf_full), 0);
    end

    // Overrun and recovery (R8, R9, R10)
    cfg_div = 8'd1;
    wait_irq(500, got);
    check(got, "R8 first frame held", int'(got), 1);
    exp_a = exp_byte(next_rx);
    check(rd_data == exp_a, "R8 held byte", int'(rd_data), int'(exp_a));
    @(negedge clk);
    ni = nirq;
    got = 0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (ovr_flag) begin got = 1; break; end
    end
    check(got, "R8 overrun flagged", int'(got), 1);
    check(nirq == ni, "R8 no irq on overrun", nirq - ni, 0);
    check(rd_data == exp_a, "R8 older byte kept", int'(rd_data), int'(exp_a));
    check(buf_full == 1'b1, "R8 still full", int'(buf_full), 1);
    n0 = nfall;
    repeat (40) @(negedge clk);
    check(nfall == n0, "R8 clock stalled", nfall - n0, 0);
    check(sck_o == 1'b1, "R8 stalled high", int'(sck_o), 1);
    check(ovr_flag == 1'b1, "R10 sticky before read", int'(ovr_flag), 1);
    do_read();
    next_rx++;
    check(rx_irq == 1'b1, "R9 irq after read", int'(rx_irq), 1);
    check(rd_data == exp_byte(next_rx), "R9 pending byte moved", int'(rd_data), int'(exp_byte(next_rx)));
    check(buf_full == 1'b1, "R9 full stays", int'(buf_full), 1);
    next_rx++;
    n0 = nfall;
    repeat (8) @(negedge clk);
    check(nfall > n0, "R9 clock resumes", nfall - n0, 1);
    check(ovr_flag == 1'b1, "R10 sticky after read", int'(ovr_flag), 1);
    ovr_clr = 1'b1;
    @(negedge clk);
    ovr_clr = 1'b0;
    check(ovr_flag == 1'b0, "R10 cleared by pulse", int'(ovr_flag), 0);
    do_read();

    // Mid-frame enable drop (R12)
    wait_irq(500, got);
    check(got, "R12 frame before drop", int'(got), 1);
    check(rd_data == exp_byte(next_rx), "R12 byte before drop", int'(rd_data), int'(exp_byte(next_rx)));
    next_rx++;
    do_read();
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if ((bitidx % 8) == 3) break;
    end
    rx_en = 1'b0;
    wait_irq(500, got);
    check(got, "R12 frame completes", int'(got), 1);
    check(rd_data == exp_byte(next_rx), "R12 last byte", int'(rd_data), int'(exp_byte(next_rx)));
    next_rx++;
    do_read();
    n0 = nfall;
    repeat (60) @(negedge clk);
    check(nfall == n0, "R12 clock stops", nfall - n0, 0);
    check((bitidx % 8) == 0, "R12 frame boundary", bitidx % 8, 0);
    check(sck_o == 1'b1, "R12 idle high", int'(sck_o), 1);

    done = 1;
    summary();
    $finish;
  end

endmodule